// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the system-side master for a three-wire successive-approximation converter with an 8-bit result. On a one-cycle start request, when idle, it latches the channel and mode request. It pulls chip-select low and waits a setup interval. It then runs a shift clock made by dividing the system clock. The first four bits it sends are a start marker and three configuration bits, and the converter takes each bit on a rising shift-clock edge.

The converter answers only after a sample window and a null bit. The controller lets those edges pass and then takes the result most significant bit first. The request can also ask the converter to repeat the result least significant bit first. In that mode the repeated bits are compared with the first copy, and any difference raises an error. After the last bit the line must read zero; a one there also raises the error. Once the transfer ends, chip-select is held high for a recovery interval before another request is taken.

Top module: `sadc_host`

## Requirements
- R1: While reset is asserted and after it, until a request is accepted, cs_n_o is 1, sclk_o is 0, mosi_o is 0, busy_o is 0 and valid_o is 0.
- R2: A request accepted while idle drives cs_n_o low on the next cycle, and sclk_o stays low for CS_SETUP cycles before its first half period begins.
- R3: While cs_n_o is low after the setup interval, sclk_o begins low and toggles every DIV_HALF system cycles. It gives 15 rising edges when replay_i was 0 at acceptance and 22 when it was 1, and it is low whenever cs_n_o is high.
- R4: mosi_o carries 1 from acceptance until the first falling edge. Each later falling edge moves it to the next of these: single_i, odd_i, then the inverse of replay_i. After the fourth falling edge it is 0. It never changes while sclk_o is high.
- R5: miso_i is sampled on rising edges only. Edges 1 to 6 are ignored (configuration, sample window, null bit), and edges 7 to 14 give result_o bits 7 down to 0.
- R6: With replay, edges 15 to 21 are compared with result bits 1 to 7 in that order, and any mismatch sets err_o.
- R7: The rising edge after the last data bit (edge 15 without replay, 22 with it) must see 0 on miso_i; a 1 sets err_o.
- R8: valid_o is a one-cycle pulse in the first cycle that cs_n_o is high after a transfer. result_o and err_o change only in that cycle and hold until the next pulse.
- R9: After a transfer, cs_n_o stays high for at least CS_HOLD cycles before it can fall again.
- R10: busy_o is 1 from the cycle after acceptance until the recovery interval ends. A start_i seen while busy_o is 1 is ignored and alters neither the running transfer nor its configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a conversion (taken only when idle) |
| single_i | input | 1 | Single-ended (1) or differential (0) selection bit |
| odd_i | input | 1 | Odd channel / polarity selection bit |
| replay_i | input | 1 | 1 asks for the LSB-first repeat and its check |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip-select, active low |
| sclk_o | output | 1 | Shift clock, idles low |
| mosi_o | output | 1 | Serial configuration data to the converter |
| busy_o | output | 1 | Transfer or recovery in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| err_o | output | 1 | Replay mismatch or non-zero trailing bit |
| result_o | output | DATA_W | Captured conversion result |

## Verification
On every cycle the assertions check several protocol rules at the pins. The shift clock is parked whenever chip-select is high, and mosi is stable through each high phase. The setup interval before the first rising edge and the minimum chip-select high time are both held. The valid pulse lands on the release of chip-select, and the error flag moves only with that pulse. What the pins cannot show in a single cycle needs the bench's converter model. That covers the exact edge counts, the order of the configuration bits, and which edges are skipped and which captured. It also covers how replay faults and a non-zero trailing bit reach the error flag, and the loss of a start request sent while busy.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_RECOVER
  } sadc_state_e;

  // Bits sent to the converter: start marker plus three settings.
  localparam int CFG_BITS   = 4;
  // Rising edges that carry nothing useful: end of sample window, null bit.
  localparam int SKIP_EDGES = 2;

  // Index (1-based) of the rising edge that carries the first result bit.
  function automatic int first_data_edge();
    return CFG_BITS + SKIP_EDGES + 1;
  endfunction

  // Index of the rising edge that carries the last MSB-first result bit.
  function automatic int last_data_edge(input int w);
    return first_data_edge() + w - 1;
  endfunction

  // Index of the rising edge that must see the trailing zero.
  function automatic int final_edge(input int w, input logic replay);
    return last_data_edge(w) + (replay ? (w - 1) : 0) + 1;
  endfunction

  // Width of a rising-edge counter able to reach final_edge with replay.
  function automatic int edge_bits(input int w);
    return $clog2(2 * w + CFG_BITS + SKIP_EDGES + 2);
  endfunction

  // Configuration word, first bit to send in the MSB position.
  function automatic logic [CFG_BITS-1:0] cfg_word(input logic single,
                                                   input logic odd,
                                                   input logic replay);
    return {1'b1, single, odd, ~replay};
  endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int DIV_HALF = 200,
  parameter int EW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [EW-1:0] last_edge_i,
  output logic          sclk_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic          finish_o,
  output logic [EW-1:0] edge_idx_o
);

  localparam int HW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [HW-1:0] HALF_END = HW'(DIV_HALF - 1);

  logic [HW-1:0] half_q;
  logic [EW-1:0] edges_q;
  logic          sclk_q;
  logic          tick_w;

  always_comb begin
    tick_w     = run_i && (half_q == HALF_END);
    rise_o     = tick_w && !sclk_q;
    fall_o     = tick_w && sclk_q;
    edge_idx_o = edges_q + EW'(1);
    finish_o   = fall_o && (edges_q == last_edge_i);
    sclk_o     = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= '0;
      edges_q <= '0;
      sclk_q  <= 1'b0;
    end else if (!run_i) begin
      half_q  <= '0;
      edges_q <= '0;
      sclk_q  <= 1'b0;
    end else begin
      half_q <= tick_w ? '0 : half_q + HW'(1);
      if (tick_w) sclk_q <= !sclk_q;
      if (rise_o) edges_q <= edge_idx_o;
    end
  end

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl #(
  parameter int CS_SETUP = 100,
  parameter int CS_HOLD  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic single_i,
  input  logic odd_i,
  input  logic replay_i,
  input  logic fall_i,
  input  logic finish_i,
  output logic accept_o,
  output logic run_o,
  output logic busy_o,
  output logic cs_n_o,
  output logic mosi_o,
  output logic replay_o
);
  import sadc_pkg::*;

  localparam int CMAX = (CS_SETUP > CS_HOLD) ? CS_SETUP : CS_HOLD;
  localparam int CW   = $clog2(CMAX + 1);

  sadc_state_e         state_q;
  logic [CW-1:0]       cnt_q;
  logic [CFG_BITS-1:0] cfg_q;
  logic                rep_q;
  logic                setup_done_w;
  logic                hold_done_w;

  always_comb begin
    accept_o     = start_i && (state_q == ST_IDLE);
    run_o        = (state_q == ST_SHIFT);
    busy_o       = (state_q != ST_IDLE);
    cs_n_o       = !((state_q == ST_SETUP) || (state_q == ST_SHIFT));
    mosi_o       = cfg_q[CFG_BITS-1];
    replay_o     = rep_q;
    setup_done_w = (state_q == ST_SETUP) && (cnt_q == CW'(CS_SETUP - 1));
    hold_done_w  = (state_q == ST_RECOVER) && (cnt_q == CW'(CS_HOLD - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cfg_q   <= '0;
      rep_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_SETUP;
            cnt_q   <= '0;
            cfg_q   <= cfg_word(single_i, odd_i, replay_i);
            rep_q   <= replay_i;
          end
        end
        ST_SETUP: begin
          if (setup_done_w) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_SHIFT: begin
          if (fall_i) cfg_q <= {cfg_q[CFG_BITS-2:0], 1'b0};
          if (finish_i) begin
            state_q <= ST_RECOVER;
            cnt_q   <= '0;
          end
        end
        ST_RECOVER: begin
          if (hold_done_w) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q + CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int W  = 8,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          rise_i,
  input  logic          finish_i,
  input  logic          replay_i,
  input  logic          miso_i,
  input  logic [EW-1:0] edge_idx_i,
  output logic [W-1:0]  result_o,
  output logic          valid_o,
  output logic          err_o
);
  import sadc_pkg::*;

  localparam int FIRST = first_data_edge();
  localparam int LASTD = last_data_edge(W);
  localparam int RLAST = LASTD + W - 1;

  int           k_w;
  logic         data_edge_w;
  logic         replay_edge_w;
  logic         tail_edge_w;
  logic [W-1:0] shreg_q;
  logic [W-1:0] cmp_q;
  logic         mism_q;
  logic         tail_q;

  always_comb begin
    k_w           = int'(edge_idx_i);
    data_edge_w   = rise_i && (k_w >= FIRST) && (k_w <= LASTD);
    replay_edge_w = rise_i && replay_i && (k_w > LASTD) && (k_w <= RLAST);
    tail_edge_w   = rise_i && (k_w == final_edge(W, replay_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      cmp_q    <= '0;
      mism_q   <= 1'b0;
      tail_q   <= 1'b0;
      result_o <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= finish_i;
      if (clear_i) begin
        mism_q <= 1'b0;
        tail_q <= 1'b0;
      end
      if (data_edge_w) begin
        shreg_q <= {shreg_q[W-2:0], miso_i};
        // Bits 1..W-1 of the finished word, lowest first, for the replay.
        if (k_w == LASTD) cmp_q <= {1'b0, shreg_q[W-2:0]};
      end
      if (replay_edge_w) begin
        mism_q <= mism_q | (miso_i ^ cmp_q[0]);
        cmp_q  <= cmp_q >> 1;
      end
      if (tail_edge_w) tail_q <= miso_i;
      if (finish_i) begin
        result_o <= shreg_q;
        err_o    <= mism_q | tail_q;
      end
    end
  end

endmodule

// File: rtl/sadc_host.sv
module sadc_host #(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 200,
  parameter int CS_SETUP = 100,
  parameter int CS_HOLD  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              single_i,
  input  logic              odd_i,
  input  logic              replay_i,
  input  logic              miso_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic              err_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int EW = sadc_pkg::edge_bits(DATA_W);

  logic          accept_w;
  logic          run_w;
  logic          rise_w;
  logic          fall_w;
  logic          finish_w;
  logic          rep_w;
  logic [EW-1:0] edge_idx_w;
  logic [EW-1:0] last_edge_w;

  assign last_edge_w = EW'(sadc_pkg::final_edge(DATA_W, rep_w));

  sadc_ctrl #(
    .CS_SETUP(CS_SETUP),
    .CS_HOLD (CS_HOLD)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .single_i(single_i),
    .odd_i   (odd_i),
    .replay_i(replay_i),
    .fall_i  (fall_w),
    .finish_i(finish_w),
    .accept_o(accept_w),
    .run_o   (run_w),
    .busy_o  (busy_o),
    .cs_n_o  (cs_n_o),
    .mosi_o  (mosi_o),
    .replay_o(rep_w)
  );

  sadc_sclk_gen #(
    .DIV_HALF(DIV_HALF),
    .EW      (EW)
  ) u_sclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_w),
    .last_edge_i(last_edge_w),
    .sclk_o     (sclk_o),
    .rise_o     (rise_w),
    .fall_o     (fall_w),
    .finish_o   (finish_w),
    .edge_idx_o (edge_idx_w)
  );

  sadc_capture #(
    .W (DATA_W),
    .EW(EW)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (accept_w),
    .rise_i    (rise_w),
    .finish_i  (finish_w),
    .replay_i  (rep_w),
    .miso_i    (miso_i),
    .edge_idx_i(edge_idx_w),
    .result_o  (result_o),
    .valid_o   (valid_o),
    .err_o     (err_o)
  );

endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
  parameter int CS_SETUP = 100,
  parameter int CS_HOLD  = 100
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic busy_o,
  input logic valid_o,
  input logic err_o,
  input logic accept_w
);

  int   lo_cnt;
  int   hi_cnt;
  logic seen_rise;

  // Cycles with chip-select low before the first shift-clock rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt    <= 0;
      seen_rise <= 1'b0;
    end else if (cs_n_o) begin
      lo_cnt    <= 0;
      seen_rise <= 1'b0;
    end else begin
      if (!sclk_o && !seen_rise) lo_cnt <= lo_cnt + 1;
      if (sclk_o) seen_rise <= 1'b1;
    end
  end

  // Cycles with chip-select high, saturating at the hold count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_cnt <= CS_HOLD;
    else if (!cs_n_o)         hi_cnt <= 0;
    else if (hi_cnt < CS_HOLD) hi_cnt <= hi_cnt + 1;
  end

  p_sclk_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  p_cs_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_o) && !seen_rise) |-> (lo_cnt >= CS_SETUP));

  p_mosi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(mosi_o));

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_valid_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));

  p_err_moves_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(err_o));

  p_cs_recovery_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt >= CS_HOLD));

  p_busy_covers_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  p_accept_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (busy_o && !cs_n_o));

endmodule

bind sadc_host sadc_host_chk #(
  .CS_SETUP(CS_SETUP),
  .CS_HOLD (CS_HOLD)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n_o  (cs_n_o),
  .sclk_o  (sclk_o),
  .mosi_o  (mosi_o),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .err_o   (err_o),
  .accept_w(accept_w)
);

// File: tb/sadc_host_bench.sv
module sadc_host_bench;
  localparam int W = 8;
  localparam int D = 3;
  localparam int S = 5;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sgl = 1'b0, odd = 1'b0, rep = 1'b0;
  logic miso = 1'b1;
  logic cs_n_o, sclk_o, mosi_o, busy_o, valid_o, err_o;
  logic [W-1:0] result_o;

  always #5 clk = ~clk;

  sadc_host #(.DATA_W(W), .DIV_HALF(D), .CS_SETUP(S), .CS_HOLD(H)) u_sadc_host (
    .clk(clk), .rst_n(rst_n), .start_i(start), .single_i(sgl), .odd_i(odd),
    .replay_i(rep), .miso_i(miso), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .busy_o(busy_o), .valid_o(valid_o), .err_o(err_o),
    .result_o(result_o)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- converter model ----------------
  logic [W-1:0] dv_data = '0;
  logic dv_rep = 1'b0, dv_frep = 1'b0, dv_ftail = 1'b0;
  int   dv_r = 0;
  logic sclk_prev = 1'b0;

  function automatic logic dev_bit(input int k);
    if (k <= 5) return 1'b1;                       // junk before the null bit
    if (k == 6) return 1'b0;                       // null bit
    if (k <= 6 + W) return dv_data[6 + W - k];     // MSB first
    if (dv_rep && k <= 5 + 2 * W)                  // LSB-first repeat of bits 1..7
      return dv_data[k - 6 - W] ^ (dv_frep && (k == 9 + W));
    if (k == (dv_rep ? 6 + 2 * W : 7 + W)) return dv_ftail;
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (cs_n_o) begin
      dv_r = 0;
      miso = 1'b1;
    end else begin
      if (sclk_o && !sclk_prev) dv_r = dv_r + 1;
      if (!sclk_o && sclk_prev) miso = dev_bit(dv_r + 1);
    end
    sclk_prev = sclk_o;
  end

  // ---------------- reference model ----------------
  int n = -1;
  logic m_sgl = 0, m_odd = 0, m_rep = 0, m_err = 0;
  logic [W-1:0] m_data = '0;
  logic [W-1:0] held_res = '0;
  logic held_err = 0, have_res = 0;

  function automatic int last_e(input logic r);
    return r ? 6 + 2 * W : 7 + W;
  endfunction

  function automatic int total(input logic r);
    return S + 2 * last_e(r) * D + H;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) n <= -1;
    else if (n < 0) begin
      if (start) begin
        n      <= 0;
        m_sgl  <= sgl;
        m_odd  <= odd;
        m_rep  <= rep;
        m_data <= dv_data;
        m_err  <= dv_ftail || (rep && dv_frep);
      end
    end else n <= (n + 1 >= total(m_rep)) ? -1 : n + 1;
  end

  always @(negedge clk) begin
    logic e_cs, e_sclk, e_busy, e_mosi, e_valid;
    int   shift_end;
    e_cs = 1; e_sclk = 0; e_busy = 0; e_mosi = 0; e_valid = 0;
    shift_end = S + 2 * last_e(m_rep) * D;
    if (n >= 0) begin
      e_busy = 1;
      if (n < S) begin
        e_cs = 0; e_mosi = 1;
      end else if (n < shift_end) begin
        int j, idx;
        j = (n - S) / D;
        idx = j / 2;
        e_cs = 0;
        e_sclk = j[0];
        e_mosi = (idx == 0) ? 1'b1 : (idx == 1) ? m_sgl : (idx == 2) ? m_odd :
                 (idx == 3) ? !m_rep : 1'b0;
      end else e_valid = (n == shift_end);
    end
    if (!rst_n) begin
      chk(cs_n_o == 1 && sclk_o == 0 && mosi_o == 0 && busy_o == 0 && valid_o == 0,
          "R1", "idle pins", {cs_n_o, sclk_o, mosi_o, busy_o, valid_o}, 5'b10000);
    end else begin
      chk(cs_n_o == e_cs, (e_cs && n >= 0) ? "R9" : "R2", "cs_n", cs_n_o, e_cs);
      chk(sclk_o == e_sclk, "R3", "sclk", sclk_o, e_sclk);
      chk(mosi_o == e_mosi, "R4", "mosi", mosi_o, e_mosi);
      chk(busy_o == e_busy, "R10", "busy", busy_o, e_busy);
      chk(valid_o == e_valid, "R8", "valid", valid_o, e_valid);
      if (e_valid) begin
        chk(result_o == m_data, "R5", "result", result_o, m_data);
        chk(err_o == m_err, dv_ftail ? "R7" : "R6", "err", err_o, m_err);
        held_res = m_data;
        held_err = m_err;
        have_res = 1;
      end else if (have_res) begin
        chk(result_o == held_res && err_o == held_err, "R8", "held result/err",
            {err_o, result_o}, {held_err, held_res});
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input logic a_sgl, input logic a_odd, input logic a_rep,
                      input logic [W-1:0] d, input logic fr, input logic ft,
                      input bit poke);
    dv_data = d; dv_rep = a_rep; dv_frep = fr; dv_ftail = ft;
    sgl = a_sgl; odd = a_odd; rep = a_rep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: a request while busy must leave the transfer untouched
      repeat (30) @(negedge clk);
      sgl = ~a_sgl; odd = ~a_odd; rep = ~a_rep; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(1, 0, 0, 8'hA5, 0, 0, 0);   // R5 plain MSB-first
    xfer(0, 1, 1, 8'h3C, 0, 0, 0);   // R6 clean replay
    xfer(1, 1, 1, 8'h81, 1, 0, 0);   // R6 replay mismatch
    xfer(0, 0, 0, 8'h5A, 0, 1, 0);   // R7 trailing one, no replay
    xfer(1, 0, 1, 8'hFF, 0, 1, 0);   // R7 trailing one after replay
    xfer(0, 1, 0, 8'h00, 0, 0, 0);   // R5 all zero
    xfer(1, 1, 0, 8'hC3, 0, 0, 1);   // R10 start while busy
    xfer(0, 0, 1, 8'h69, 0, 0, 0);   // R9 back-to-back request
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule